// File: doc/BRIEF.md
# Two-Pulse Vectored Interrupt Controller

This block gathers up to eight interrupt request lines and presents one interrupt line to a processor that acknowledges with two pulses. Each request line is edge-sensitive: a rising edge latches a pending request. The controller resolves pending requests under a fixed priority. A request can interrupt the processor only if it is unmasked and has higher priority than any level already being serviced. When at least one request meets these conditions, the interrupt output is high.

On the first acknowledge pulse the controller picks the winning request. It moves that request from pending to in-service and holds its index. On the second acknowledge pulse it places an 8-bit vector number on its data output for one cycle. The vector number is a programmable base plus the held index. If nothing was eligible at the first pulse, it returns the code for the lowest-priority input. Software uses a small write port to set the vector base and the mask, and to issue an end-of-interrupt command that retires the highest-priority in-service level.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, intOut, vecOe and vecOut are all 0. The vector base is 32, the mask is 0, and no request is pending or in service.
- R2: A 0-to-1 transition on irqIn[i] latches request i. intOut is high after the first clock edge that samples the line high. A line that simply stays high does not latch the request again once it has been served.
- R3: Priority is fixed: a lower index wins, so irqIn[0] is highest and irqIn[7] is lowest.
- R4: An acknowledge pulse is ackIn high for one clock. The first pulse clears the winning request and marks it in service. The second pulse makes vecOe high, with the vector on vecOut, for exactly the one cycle after the edge that samples it.
- R5: The vector is base + index. With the reset base, input 6 gives 38 and input 7 gives 39. A write to register address 0 sets the base.
- R6: A write to register address 1 sets the mask. When mask bit i is 1, request i can neither raise intOut nor win. The request stays pending, and clearing the mask bit lets it raise intOut again.
- R7: While in-service bit k is set, requests with index k or above do not raise intOut. Requests with index below k still do.
- R8: A write to register address 2, with any data, clears the lowest-index set in-service bit.
- R9: If no request is eligible at the first pulse, the second pulse returns base + 7 and no in-service bit is set.
- R10: vecOut reads 0 whenever vecOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Request lines, rising-edge sensitive |
| ackIn | input | 1 | Acknowledge pulse from the processor |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 base, 1 mask, 2 end-of-interrupt |
| wrData | input | 8 | Register write data |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector number, valid while vecOe is high |
| vecOe | output | 1 | Vector drive enable |

## Verification
A request edge shows up on intOut one edge after the line is sampled high. A mask or end-of-interrupt write affects intOut one edge after the write is sampled. The vector appears on the edge that samples the second acknowledge pulse and is gone one edge later. The bench drives every input just after a falling edge. It reads the outputs at the next falling edge, which lies exactly one rising edge later. It also reads vecOe and vecOut once more a cycle after that, to confirm the one-cycle drive window.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_MASK = 2'd1,
    REG_EOI  = 2'd2
  } regSel_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } ackPhase_e;

  typedef struct packed {
    logic freeze;
    logic emit;
    logic eoi;
    logic wrBase;
    logic wrMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackIn,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  output ctrlStrobe_t strobe
);
  ackPhase_e phase;

  // Two-pulse acknowledge sequencer: the first pulse freezes, the second emits (R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else if (ackIn) phase <= (phase == PH_IDLE) ? PH_WAIT : PH_IDLE;
  end

  always_comb begin
    strobe        = '0;
    strobe.freeze = ackIn && (phase == PH_IDLE);
    strobe.emit   = ackIn && (phase == PH_WAIT);
    strobe.wrBase = wrEn && (wrAddr == REG_BASE);
    strobe.wrMask = wrEn && (wrAddr == REG_MASK);
    strobe.eoi    = wrEn && (wrAddr == REG_EOI);
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int VEC_W     = 8,
  parameter int BASE_INIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [VEC_W-1:0]  wrData,
  input  ctrlStrobe_t       strobe,
  output logic              intOut,
  output logic [VEC_W-1:0]  vecOut,
  output logic              vecOe
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IN - 1);

  logic [NUM_IN-1:0] irqPrev, reqPend, inSvc, maskReg;
  logic [NUM_IN-1:0] riseDet, eligible, svcAllow, eoiHit, grant;
  logic [VEC_W-1:0]  baseReg, vecReg;
  logic [IDX_W-1:0]  winIdx, heldIdx;
  logic              winFound, heldValid, vecOeReg;

  assign riseDet = irqIn & ~irqPrev;

  // A level is allowed only if no in-service level at or above it (R7)
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      acc         = acc | inSvc[i];
      svcAllow[i] = ~acc;
    end
  end

  assign eligible = reqPend & ~maskReg & svcAllow;
  assign intOut   = |eligible;

  // Fixed priority, lowest index wins (R3)
  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winIdx   = IDX_W'(i);
        winFound = 1'b1;
      end
    end
  end

  // End-of-interrupt targets the highest-priority in-service level (R8)
  always_comb begin
    logic seen;
    seen   = 1'b0;
    eoiHit = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (inSvc[i] && !seen) begin
        eoiHit[i] = strobe.eoi;
        seen      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : gLine
      assign grant[g] = strobe.freeze && winFound && (winIdx == IDX_W'(g));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          reqPend[g] <= 1'b0;
          inSvc[g]   <= 1'b0;
        end else begin
          reqPend[g] <= (reqPend[g] & ~grant[g]) | riseDet[g];
          inSvc[g]   <= (inSvc[g] & ~eoiHit[g]) | grant[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      baseReg <= VEC_W'(BASE_INIT);
    end else begin
      if (strobe.wrMask) maskReg <= wrData[NUM_IN-1:0];
      if (strobe.wrBase) baseReg <= wrData;
    end
  end

  // Snapshot of the selection taken at the first pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldIdx   <= '0;
      heldValid <= 1'b0;
    end else if (strobe.freeze) begin
      heldIdx   <= winIdx;
      heldValid <= winFound;
    end
  end

  // Vector drive window, one cycle, zero otherwise (R4, R9, R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg   <= '0;
      vecOeReg <= 1'b0;
    end else if (strobe.emit) begin
      vecReg   <= baseReg + VEC_W'(heldValid ? heldIdx : LAST_IDX);
      vecOeReg <= 1'b1;
    end else begin
      vecReg   <= '0;
      vecOeReg <= 1'b0;
    end
  end

  assign vecOut = vecReg;
  assign vecOe  = vecOeReg;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_IN    = 8,
  parameter int VEC_W     = 8,
  parameter int BASE_INIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              ackIn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [VEC_W-1:0]  wrData,
  output logic              intOut,
  output logic [VEC_W-1:0]  vecOut,
  output logic              vecOe
);
  ctrlStrobe_t strobe;

  vic_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ackIn  (ackIn),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  vic_datapath #(
    .NUM_IN    (NUM_IN),
    .VEC_W     (VEC_W),
    .BASE_INIT (BASE_INIT)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .wrData (wrData),
    .strobe (strobe),
    .intOut (intOut),
    .vecOut (vecOut),
    .vecOe  (vecOe)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_IN = 8,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] irqIn,
  input logic              ackIn,
  input logic              wrEn,
  input logic              intOut,
  input logic [VEC_W-1:0]  vecOut,
  input logic              vecOe
);
  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> $past((|irqIn) || wrEn)); // R2

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecOe) |-> $past(ackIn)); // R4

  AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |=> !vecOe); // R4

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !vecOe |-> (vecOut == '0)); // R10
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NUM_IN (NUM_IN),
  .VEC_W  (VEC_W)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .irqIn  (irqIn),
  .ackIn  (ackIn),
  .wrEn   (wrEn),
  .intOut (intOut),
  .vecOut (vecOut),
  .vecOe  (vecOe)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       intOut;
  logic [7:0] vecOut;
  logic       vecOe;

  int nChecks = 0;
  int nFails  = 0;

  localparam int NPAT = 8;
  localparam logic [7:0] PATS [NPAT] = '{8'h01, 8'h80, 8'h40, 8'h90,
                                         8'h0A, 8'hFF, 8'h24, 8'h11};

  always #5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackIn(ackIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .intOut(intOut), .vecOut(vecOut), .vecOe(vecOe)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseIrq(input logic [7:0] pat);
    irqIn = pat; step();
    irqIn = '0;  step();
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; step();
    wrEn = 1'b0; wrData = '0;
  endtask

  // Full two-pulse acknowledge; checks the vector and the drive window (R4)
  task automatic ackCycle(input int expVec, input string req);
    ackIn = 1'b1; step();
    ackIn = 1'b0; step();
    ackIn = 1'b1; step();
    ackIn = 1'b0;
    check(vecOe === 1'b1, "R4 vecOe on second pulse", int'(vecOe), 1);
    check(vecOut === 8'(expVec), req, int'(vecOut), expVec);
    step();
    check(vecOe === 1'b0 && vecOut === 8'd0, "R10 bus quiet after drive", int'(vecOut), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    // R1: reset state
    check(intOut === 1'b0, "R1 intOut after reset", int'(intOut), 0);
    check(vecOe === 1'b0 && vecOut === 8'd0, "R1 bus after reset", int'(vecOut), 0);

    // Table walk: every set bit served in priority order (R2, R3, R5, R8)
    for (int p = 0; p < NPAT; p++) begin
      pulseIrq(PATS[p]);
      for (int b = 0; b < 8; b++) begin
        if (PATS[p][b]) begin
          check(intOut === 1'b1, "R2 intOut with pending request", int'(intOut), 1);
          ackCycle(32 + b, "R3 priority winner vector");
          writeReg(2'd2, 8'h00);
          step();
        end
      end
      check(intOut === 1'b0, "R8 all levels retired", int'(intOut), 0);
    end

    // R5: IR6 and IR7 with default base, then reprogrammed base
    pulseIrq(8'h40);
    ackCycle(38, "R5 IR6 vector 38");
    writeReg(2'd2, 8'h00);
    pulseIrq(8'h80);
    ackCycle(39, "R5 IR7 vector 39");
    writeReg(2'd2, 8'h00);
    writeReg(2'd0, 8'h40);
    pulseIrq(8'h40);
    ackCycle(8'h46, "R5 programmed base");
    writeReg(2'd2, 8'h00);
    writeReg(2'd0, 8'd32);

    // R6: masked request stays pending
    writeReg(2'd1, 8'h04);
    pulseIrq(8'h04);
    check(intOut === 1'b0, "R6 masked request blocked", int'(intOut), 0);
    writeReg(2'd1, 8'h00);
    step();
    check(intOut === 1'b1, "R6 unmask raises intOut", int'(intOut), 1);
    ackCycle(34, "R6 unmasked vector");
    writeReg(2'd2, 8'h00);

    // R7 / R8: nesting by priority
    pulseIrq(8'h08);
    ackCycle(35, "R7 first level vector");
    pulseIrq(8'h20);
    check(intOut === 1'b0, "R7 lower level blocked", int'(intOut), 0);
    pulseIrq(8'h08);
    check(intOut === 1'b0, "R7 equal level blocked", int'(intOut), 0);
    pulseIrq(8'h02);
    check(intOut === 1'b1, "R7 higher level passes", int'(intOut), 1);
    ackCycle(33, "R7 nested vector");
    writeReg(2'd2, 8'h00);
    step();
    check(intOut === 1'b0, "R8 EOI clears only top level", int'(intOut), 0);
    writeReg(2'd2, 8'h00);
    step();
    check(intOut === 1'b1, "R8 second EOI unblocks", int'(intOut), 1);
    ackCycle(35, "R8 repeated level 3 vector");
    writeReg(2'd2, 8'h00);
    ackCycle(37, "R8 pending level 5 vector");
    writeReg(2'd2, 8'h00);
    step();
    check(intOut === 1'b0, "R8 drained", int'(intOut), 0);

    // R9: spurious acknowledge, nothing set in service
    ackCycle(39, "R9 spurious vector");
    pulseIrq(8'h80);
    check(intOut === 1'b1, "R9 no level left in service", int'(intOut), 1);
    ackCycle(39, "R9 real IR7 after spurious");
    writeReg(2'd2, 8'h00);

    // R2: held level is not re-latched
    irqIn = 8'h10; step();
    ackCycle(36, "R2 held line served");
    writeReg(2'd2, 8'h00);
    step(); step();
    check(intOut === 1'b0, "R2 held level not re-latched", int'(intOut), 0);
    irqIn = '0; step();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule